// File: doc/BRIEF.md
# Private Cache Line Coherence Controller

This block holds the coherence state of every line in a small innermost private cache that sits under a private next-level cache. The protocol is invalidation-based with modified, exclusive, shared and invalid stable states. Each cycle the block accepts at most one event: a processor request (load, instruction fetch, store or replacement) or a decoded network message from the next level. It updates the state of the addressed line and, one clock later, reports a request or response message, a completion strobe and an eviction notice.

Lines with a request outstanding sit in one of three transient states: fill-for-read, fill-for-write, or upgrade-from-shared. Any processor event aimed at such a line is held off with a stall until a fill completes it. The data array, tag lookup and network transport live elsewhere. The controller sees only line indices and message classes. A permission query port reports the access right of any line without side effects.

Top module: `coh_line_ctrl`

## Requirements
- R1: After synchronous reset every line is not-present (query reports 0), and msg_valid, done_hit, evict_notice and proto_err are low. Outputs pulse only in the clock cycle after the event that caused them, with rsp_line set to that event's line.
- R2: Encodings. proc_op: 0 load, 1 instruction fetch, 2 store, 3 replacement. net_class: 0 data, 1 exclusive data, 2 stale data, 3 invalidate, 4 forwarded exclusive request, 5 forwarded shared request, 6 forwarded fetch request, 7 writeback acknowledge. msg_kind: 0 GETS, 1 GETX, 2 UPGRADE, 3 PUTX, 4 INV_ACK, 5 INV_DATA. qry_perm: 0 for not-present and invalid, 1 (busy) for fill-for-read and fill-for-write, 2 (read-only) for shared, exclusive and upgrade-pending, 3 (read-write) for modified.
- R3: A load or fetch to a shared, exclusive or modified line raises done_hit, sends no message, and leaves the line's permission unchanged.
- R4: A store to an exclusive or modified line raises done_hit and leaves the line modified and dirty. A store to a shared line sends UPGRADE and moves to upgrade-pending.
- R5: From not-present or invalid, a load or fetch sends GETS and enters fill-for-read, and a store sends GETX and enters fill-for-write. Request messages are never data-sized.
- R6: In fill-for-read, data gives shared, exclusive data gives exclusive, and stale data leaves the line invalid. Each of these raises done_hit. In fill-for-write or upgrade-pending, exclusive data gives modified and raises done_hit. Fills in any other state, and writeback acknowledges, change nothing and send nothing.
- R7: An invalidate is answered with INV_ACK in not-present, invalid, fill-for-read and fill-for-write, with no state change. In upgrade-pending it is answered with INV_ACK and the line falls back to fill-for-write. In shared or exclusive it is answered with INV_ACK and the line goes invalid. In modified it is answered with a data-sized INV_DATA carrying msg_dirty=1 and the line goes invalid.
- R8: A forwarded exclusive request to an exclusive line sends INV_ACK only, and to a modified line sends data-sized INV_DATA with dirty set. Either way the line goes invalid. A forwarded shared or fetch request to an exclusive or modified line sends data-sized INV_DATA carrying the line's dirty flag and downgrades the line to shared. These requests have no effect in other states.
- R9: Replacement of a shared line goes invalid with no message. Replacement of an exclusive line sends a control-sized PUTX with msg_dirty=0. Replacement of a modified line sends a data-sized PUTX with msg_dirty=1. Both go invalid. Replacement of an invalid or not-present line sends nothing.
- R10: A processor event aimed at a line in a transient state raises proc_stall in the same cycle and has no effect.
- R11: evict_notice pulses when an event takes a line from shared, exclusive or modified to invalid or not-present, and only if evict_en was high with that event.
- R12: When net_valid and proc_valid are high together, the network message is processed and proc_stall is raised, so the processor request has no effect.
- R13: A net_class of 8 to 15 sets proto_err, which stays set until reset, and causes no message, no completion and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_valid | input | 1 | Processor event present |
| proc_op | input | 2 | Processor event code |
| proc_line | input | LINE_W | Line index of the processor event |
| proc_stall | output | 1 | Processor event not taken this cycle |
| net_valid | input | 1 | Network message present |
| net_class | input | 4 | Decoded message class |
| net_line | input | LINE_W | Line index of the network message |
| evict_en | input | 1 | Enables eviction notices |
| qry_line | input | LINE_W | Line whose permission is reported |
| qry_perm | output | 2 | Permission of qry_line |
| msg_valid | output | 1 | Message to next level valid |
| msg_kind | output | 3 | Message kind |
| rsp_line | output | LINE_W | Line of the reported event |
| msg_dirty | output | 1 | Dirty flag carried by PUTX or INV_DATA |
| msg_data_sized | output | 1 | Message carries a data block |
| done_hit | output | 1 | Processor access completed |
| evict_notice | output | 1 | Line lost its valid copy |
| proto_err | output | 1 | Sticky unknown-class error |

## Verification
The checker assumes the processor holds a stalled request and does not count it as taken. It also assumes that at most one event per cycle reaches a line, which the priority rule guarantees. The bench drives only one event per call and lets each result settle before the next event. The bench brings every line into each of the eight states through legal sequences (a flush, then the misses and fills that lead there), so each state is reached through a legal path. Each event code, including one unknown class, is then applied from each state, with the eviction enable both off and on. The overlap of a network message with a processor request is exercised on separate lines.

// File: rtl/coh_line_pkg.sv
package coh_line_pkg;

    typedef enum logic [2:0] {
        ST_NP, ST_I, ST_S, ST_E, ST_M, ST_IS, ST_IM, ST_SM
    } line_st_e;

    typedef enum logic [1:0] {
        OP_LOAD, OP_IFETCH, OP_STORE, OP_REPL
    } proc_op_e;

    typedef enum logic [2:0] {
        NC_DATA, NC_DATA_EXCL, NC_STALE, NC_INV,
        NC_FWD_X, NC_FWD_S, NC_FWD_I, NC_WB_ACK
    } net_cls_e;

    typedef enum logic [2:0] {
        MK_GETS, MK_GETX, MK_UPGRADE, MK_PUTX, MK_INV_ACK, MK_INV_DATA
    } msg_kind_e;

    typedef enum logic [1:0] {
        PERM_NONE, PERM_BUSY, PERM_RO, PERM_RW
    } perm_e;

    typedef struct packed {
        line_st_e st;
        logic     dirty;
    } line_rec_t;

    typedef struct packed {
        logic      vld;
        msg_kind_e kind;
        logic      dirty;
        logic      big;
    } msg_t;

    typedef struct packed {
        line_rec_t nxt;
        logic      wr;
        msg_t      msg;
        logic      hit;
        logic      leave;
        logic      bad;
    } step_t;

    localparam line_rec_t REC_RESET = '{st: ST_NP, dirty: 1'b0};

    function automatic logic is_transient(line_st_e s);
        return (s == ST_IS) || (s == ST_IM) || (s == ST_SM);
    endfunction

    function automatic logic is_held(line_st_e s);
        return (s == ST_S) || (s == ST_E) || (s == ST_M);
    endfunction

    function automatic perm_e perm_of(line_st_e s);
        case (s)
            ST_M:                 return PERM_RW;
            ST_S, ST_E, ST_SM:    return PERM_RO;
            ST_IS, ST_IM:         return PERM_BUSY;
            default:              return PERM_NONE;
        endcase
    endfunction

    function automatic msg_t mk_msg(msg_kind_e k, logic d, logic b);
        msg_t m;
        m.vld   = 1'b1;
        m.kind  = k;
        m.dirty = d;
        m.big   = b;
        return m;
    endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_line_pkg::*;
#(
    parameter int NUM_LINES = 64,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_idx,
    input  line_rec_t         wr_rec,
    output line_rec_t         recs_o [NUM_LINES]
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                recs_o[g] <= REC_RESET;
            end else if (wr_en && (wr_idx == LINE_W'(g))) begin
                recs_o[g] <= wr_rec;
            end
        end
    end

endmodule

// File: rtl/coh_line_next.sv
module coh_line_next
    import coh_line_pkg::*;
(
    input  logic      net_v,
    input  logic [3:0] net_cls,
    input  logic      proc_v,
    input  proc_op_e  op,
    input  line_rec_t cur,
    output step_t     step
);

    net_cls_e cls;
    assign cls = net_cls_e'(net_cls[2:0]);

    always_comb begin
        step     = '0;
        step.nxt = cur;
        if (net_v) begin
            if (net_cls[3]) begin
                step.bad = 1'b1;
            end else begin
                step.wr = 1'b1;
                case (cls)
                    NC_DATA: begin
                        if (cur.st == ST_IS) begin
                            step.nxt = '{st: ST_S, dirty: 1'b0};
                            step.hit = 1'b1;
                        end
                    end
                    NC_DATA_EXCL: begin
                        if (cur.st == ST_IS) begin
                            step.nxt = '{st: ST_E, dirty: 1'b0};
                            step.hit = 1'b1;
                        end else if (cur.st == ST_IM || cur.st == ST_SM) begin
                            step.nxt = '{st: ST_M, dirty: 1'b1};
                            step.hit = 1'b1;
                        end
                    end
                    NC_STALE: begin
                        if (cur.st == ST_IS) begin
                            step.nxt = '{st: ST_I, dirty: 1'b0};
                            step.hit = 1'b1;
                        end
                    end
                    NC_INV: begin
                        step.msg = mk_msg(MK_INV_ACK, 1'b0, 1'b0);
                        case (cur.st)
                            ST_SM:      step.nxt.st = ST_IM;
                            ST_S, ST_E: step.nxt = '{st: ST_I, dirty: 1'b0};
                            ST_M: begin
                                step.msg = mk_msg(MK_INV_DATA, cur.dirty, 1'b1);
                                step.nxt = '{st: ST_I, dirty: 1'b0};
                            end
                            default: ;
                        endcase
                    end
                    NC_FWD_X: begin
                        if (cur.st == ST_E) begin
                            step.msg = mk_msg(MK_INV_ACK, 1'b0, 1'b0);
                            step.nxt = '{st: ST_I, dirty: 1'b0};
                        end else if (cur.st == ST_M) begin
                            step.msg = mk_msg(MK_INV_DATA, cur.dirty, 1'b1);
                            step.nxt = '{st: ST_I, dirty: 1'b0};
                        end
                    end
                    NC_FWD_S, NC_FWD_I: begin
                        if (cur.st == ST_E || cur.st == ST_M) begin
                            step.msg = mk_msg(MK_INV_DATA, cur.dirty, 1'b1);
                            step.nxt = '{st: ST_S, dirty: 1'b0};
                        end
                    end
                    default: ;
                endcase
            end
        end else if (proc_v && !is_transient(cur.st)) begin
            step.wr = 1'b1;
            case (cur.st)
                ST_NP, ST_I: begin
                    case (op)
                        OP_LOAD, OP_IFETCH: begin
                            step.nxt.st = ST_IS;
                            step.msg    = mk_msg(MK_GETS, 1'b0, 1'b0);
                        end
                        OP_STORE: begin
                            step.nxt.st = ST_IM;
                            step.msg    = mk_msg(MK_GETX, 1'b0, 1'b0);
                        end
                        default: step.nxt = REC_RESET;
                    endcase
                end
                ST_S: begin
                    case (op)
                        OP_LOAD, OP_IFETCH: step.hit = 1'b1;
                        OP_STORE: begin
                            step.nxt.st = ST_SM;
                            step.msg    = mk_msg(MK_UPGRADE, 1'b0, 1'b0);
                        end
                        default: step.nxt = '{st: ST_I, dirty: 1'b0};
                    endcase
                end
                default: begin
                    case (op)
                        OP_LOAD, OP_IFETCH: step.hit = 1'b1;
                        OP_STORE: begin
                            step.nxt = '{st: ST_M, dirty: 1'b1};
                            step.hit = 1'b1;
                        end
                        default: begin
                            step.msg = mk_msg(MK_PUTX, cur.dirty, cur.dirty);
                            step.nxt = '{st: ST_I, dirty: 1'b0};
                        end
                    endcase
                end
            endcase
        end
        step.leave = is_held(cur.st) &&
                     (step.nxt.st == ST_I || step.nxt.st == ST_NP);
    end

endmodule

// File: rtl/coh_line_out.sv
module coh_line_out
    import coh_line_pkg::*;
#(
    parameter int LINE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  step_t             step,
    input  logic [LINE_W-1:0] line_in,
    input  logic              evict_en,
    output msg_t              msg_q,
    output logic [LINE_W-1:0] line_q,
    output logic              hit_q,
    output logic              evict_q,
    output logic              err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q   <= '0;
            line_q  <= '0;
            hit_q   <= 1'b0;
            evict_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            msg_q   <= step.msg;
            line_q  <= line_in;
            hit_q   <= step.hit;
            evict_q <= step.leave && evict_en;
            err_q   <= err_q || step.bad;
        end
    end

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_line_pkg::*;
#(
    parameter int NUM_LINES = 64,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              proc_valid,
    input  logic [1:0]        proc_op,
    input  logic [LINE_W-1:0] proc_line,
    output logic              proc_stall,
    input  logic              net_valid,
    input  logic [3:0]        net_class,
    input  logic [LINE_W-1:0] net_line,
    input  logic              evict_en,
    input  logic [LINE_W-1:0] qry_line,
    output logic [1:0]        qry_perm,
    output logic              msg_valid,
    output logic [2:0]        msg_kind,
    output logic [LINE_W-1:0] rsp_line,
    output logic              msg_dirty,
    output logic              msg_data_sized,
    output logic              done_hit,
    output logic              evict_notice,
    output logic              proto_err
);

    line_rec_t         recs [NUM_LINES];
    logic [LINE_W-1:0] sel_line;
    step_t             step;
    msg_t              msg_q;

    assign sel_line = net_valid ? net_line : proc_line;

    coh_line_store #(.NUM_LINES(NUM_LINES)) store_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (step.wr),
        .wr_idx (sel_line),
        .wr_rec (step.nxt),
        .recs_o (recs)
    );

    coh_line_next next_i (
        .net_v   (net_valid),
        .net_cls (net_class),
        .proc_v  (proc_valid && !net_valid),
        .op      (proc_op_e'(proc_op)),
        .cur     (recs[sel_line]),
        .step    (step)
    );

    coh_line_out #(.LINE_W(LINE_W)) out_i (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .line_in  (sel_line),
        .evict_en (evict_en),
        .msg_q    (msg_q),
        .line_q   (rsp_line),
        .hit_q    (done_hit),
        .evict_q  (evict_notice),
        .err_q    (proto_err)
    );

    assign proc_stall     = proc_valid &&
                            (net_valid || is_transient(recs[proc_line].st));
    assign qry_perm       = perm_of(recs[qry_line].st);
    assign msg_valid      = msg_q.vld;
    assign msg_kind       = msg_q.kind;
    assign msg_dirty      = msg_q.dirty;
    assign msg_data_sized = msg_q.big;

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk
    import coh_line_pkg::*;
#(
    parameter int NUM_LINES = 64,
    localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              proc_valid,
    input logic [LINE_W-1:0] proc_line,
    input logic              proc_stall,
    input logic              net_valid,
    input logic [3:0]        net_class,
    input logic              evict_en,
    input logic [LINE_W-1:0] qry_line,
    input logic [1:0]        qry_perm,
    input logic              msg_valid,
    input logic [2:0]        msg_kind,
    input logic              msg_data_sized,
    input logic              done_hit,
    input logic              evict_notice,
    input logic              proto_err
);

    AST_NET_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        proc_valid && net_valid |-> proc_stall); // R12

    AST_STALL_SILENT: assert property (@(posedge clk) disable iff (rst)
        proc_valid && proc_stall && !net_valid |=> !msg_valid && !done_hit && !evict_notice); // R10

    AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
        proc_valid && (qry_line == proc_line) && (qry_perm == PERM_BUSY) |-> proc_stall); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !proc_valid && !net_valid |=> !msg_valid && !done_hit && !evict_notice); // R1

    AST_EVICT_GATED: assert property (@(posedge clk) disable iff (rst)
        !evict_en |=> !evict_notice); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err); // R13

    AST_BAD_CLASS: assert property (@(posedge clk) disable iff (rst)
        net_valid && net_class[3] |=> proto_err && !msg_valid && !done_hit && !evict_notice); // R13

    AST_INV_DATA_SIZED: assert property (@(posedge clk) disable iff (rst)
        msg_valid && (msg_kind == MK_INV_DATA) |-> msg_data_sized); // R7

    AST_REQ_CONTROL: assert property (@(posedge clk) disable iff (rst)
        msg_valid && (msg_kind == MK_GETS || msg_kind == MK_GETX || msg_kind == MK_UPGRADE)
        |-> !msg_data_sized); // R5

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.NUM_LINES(NUM_LINES)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .proc_valid     (proc_valid),
    .proc_line      (proc_line),
    .proc_stall     (proc_stall),
    .net_valid      (net_valid),
    .net_class      (net_class),
    .evict_en       (evict_en),
    .qry_line       (qry_line),
    .qry_perm       (qry_perm),
    .msg_valid      (msg_valid),
    .msg_kind       (msg_kind),
    .msg_data_sized (msg_data_sized),
    .done_hit       (done_hit),
    .evict_notice   (evict_notice),
    .proto_err      (proto_err)
);

// File: tb/coh_line_ctrl_tb_top.sv
module coh_line_ctrl_tb_top;

    localparam int NL = 4;
    localparam int LW = 2;
    // bench state numbering
    localparam int B_NP = 0, B_I = 1, B_S = 2, B_E = 3, B_M = 4,
                   B_IS = 5, B_IM = 6, B_SM = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          proc_valid = 1'b0;
    logic [1:0]    proc_op = '0;
    logic [LW-1:0] proc_line = '0;
    logic          proc_stall;
    logic          net_valid = 1'b0;
    logic [3:0]    net_class = '0;
    logic [LW-1:0] net_line = '0;
    logic          evict_en = 1'b0;
    logic [LW-1:0] qry_line = '0;
    logic [1:0]    qry_perm;
    logic          msg_valid;
    logic [2:0]    msg_kind;
    logic [LW-1:0] rsp_line;
    logic          msg_dirty;
    logic          msg_data_sized;
    logic          done_hit;
    logic          evict_notice;
    logic          proto_err;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    bit  err_exp = 1'b0;
    logic stall_s;

    always #2.5 clk = ~clk;

    coh_line_ctrl #(.NUM_LINES(NL)) dut_i (
        .clk(clk), .rst(rst),
        .proc_valid(proc_valid), .proc_op(proc_op), .proc_line(proc_line),
        .proc_stall(proc_stall),
        .net_valid(net_valid), .net_class(net_class), .net_line(net_line),
        .evict_en(evict_en), .qry_line(qry_line), .qry_perm(qry_perm),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .rsp_line(rsp_line),
        .msg_dirty(msg_dirty), .msg_data_sized(msg_data_sized),
        .done_hit(done_hit), .evict_notice(evict_notice), .proto_err(proto_err)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int perm_exp(input int s);
        case (s)
            B_M:              return 3;
            B_S, B_E, B_SM:   return 2;
            B_IS, B_IM:       return 1;
            default:          return 0;
        endcase
    endfunction

    // one event: drive at falling edge, result visible one falling edge later
    task automatic step(input bit pv, input int op, input bit nv, input int cls, input int ln);
        proc_valid = pv;
        proc_op    = 2'(op);
        proc_line  = LW'(ln);
        net_valid  = nv;
        net_class  = 4'(cls);
        net_line   = LW'(ln);
        qry_line   = LW'(ln);
        #1;
        stall_s = proc_stall;
        @(negedge clk);
        proc_valid = 1'b0;
        net_valid  = 1'b0;
    endtask

    task automatic reach(input int s, input int ln);
        step(0, 0, 1, 1, ln);   // exclusive data
        step(0, 0, 1, 3, ln);   // invalidate
        step(1, 3, 0, 0, ln);   // replacement -> not present
        case (s)
            B_I:  begin step(1, 0, 0, 0, ln); step(0, 0, 1, 2, ln); end
            B_S:  begin step(1, 0, 0, 0, ln); step(0, 0, 1, 0, ln); end
            B_E:  begin step(1, 0, 0, 0, ln); step(0, 0, 1, 1, ln); end
            B_M:  begin step(1, 2, 0, 0, ln); step(0, 0, 1, 1, ln); end
            B_IS: step(1, 0, 0, 0, ln);
            B_IM: step(1, 2, 0, 0, ln);
            B_SM: begin step(1, 0, 0, 0, ln); step(0, 0, 1, 0, ln); step(1, 2, 0, 0, ln); end
            default: ;
        endcase
    endtask

    // expected effect of event ev (0..3 processor op, 4..11 class ev-4, 12 unknown class)
    task automatic model(input int s, input int ev, output int ns, output int mv, output int mk,
                         output int md, output int mb, output int ht, output int bd,
                         output string tag);
        ns = s; mv = 0; mk = 0; md = 0; mb = 0; ht = 0; bd = 0; tag = "R6";
        if (ev >= 12) begin
            bd = 1; tag = "R13";
        end else if (ev >= 4) begin
            case (ev - 4)
                0: if (s == B_IS) begin ns = B_S; ht = 1; end
                1: if (s == B_IS) begin ns = B_E; ht = 1; end
                   else if (s == B_IM || s == B_SM) begin ns = B_M; ht = 1; end
                2: if (s == B_IS) begin ns = B_I; ht = 1; end
                3: begin
                    tag = "R7"; mv = 1; mk = 4;
                    if (s == B_SM) ns = B_IM;
                    else if (s == B_S || s == B_E) ns = B_I;
                    else if (s == B_M) begin ns = B_I; mk = 5; md = 1; mb = 1; end
                end
                4: begin
                    tag = "R8";
                    if (s == B_E) begin mv = 1; mk = 4; ns = B_I; end
                    else if (s == B_M) begin mv = 1; mk = 5; md = 1; mb = 1; ns = B_I; end
                end
                5, 6: begin
                    tag = "R8";
                    if (s == B_E || s == B_M) begin
                        mv = 1; mk = 5; mb = 1; md = (s == B_M); ns = B_S;
                    end
                end
                default: ;
            endcase
        end else if (s >= B_IS) begin
            tag = "R10";
        end else if (s == B_NP || s == B_I) begin
            tag = "R5";
            if (ev < 2) begin ns = B_IS; mv = 1; mk = 0; end
            else if (ev == 2) begin ns = B_IM; mv = 1; mk = 1; end
            else begin ns = B_NP; tag = "R9"; end
        end else begin
            if (ev < 2) begin ht = 1; tag = "R3"; end
            else if (ev == 2) begin
                tag = "R4";
                if (s == B_S) begin ns = B_SM; mv = 1; mk = 2; end
                else begin ns = B_M; ht = 1; end
            end else begin
                tag = "R9"; ns = B_I;
                if (s != B_S) begin mv = 1; mk = 3; md = (s == B_M); mb = (s == B_M); end
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int ns, mv, mk, md, mb, ht, bd, lv;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int l = 0; l < NL; l++) begin
            qry_line = LW'(l);
            #0.5;
            chk("R1", "reset perm", int'(qry_perm), 0);
        end
        chk("R1", "msg_valid", int'(msg_valid), 0);
        chk("R1", "done_hit", int'(done_hit), 0);
        chk("R1", "evict_notice", int'(evict_notice), 0);
        chk("R1", "proto_err", int'(proto_err), 0);

        // sweep: every state x every event x eviction enable
        for (int en = 0; en < 2; en++) begin
            for (int s = 0; s < 8; s++) begin
                for (int ev = 0; ev < 13; ev++) begin
                    int ln;
                    ln = (s + ev) % NL;
                    reach(s, ln);
                    chk("R2", "perm after setup", int'(qry_perm), perm_exp(s));
                    evict_en = en[0];
                    model(s, ev, ns, mv, mk, md, mb, ht, bd, tag);
                    if (ev < 4) step(1, ev, 0, 0, ln);
                    else if (ev < 12) step(0, 0, 1, ev - 4, ln);
                    else step(0, 0, 1, 9, ln);
                    if (bd != 0) err_exp = 1'b1;
                    lv = ((s == B_S || s == B_E || s == B_M) && (ns == B_NP || ns == B_I)) ? 1 : 0;
                    if (ev < 4) chk(tag, "proc_stall", int'(stall_s), (s >= B_IS) ? 1 : 0);
                    chk(tag, "msg_valid", int'(msg_valid), mv);
                    if (mv != 0) begin
                        chk(tag, "msg_kind", int'(msg_kind), mk);
                        chk(tag, "msg_dirty", int'(msg_dirty), md);
                        chk(tag, "msg_data_sized", int'(msg_data_sized), mb);
                    end
                    chk(tag, "done_hit", int'(done_hit), ht);
                    if (mv != 0 || ht != 0) chk("R1", "rsp_line", int'(rsp_line), ln);
                    chk("R11", "evict_notice", int'(evict_notice), lv & en);
                    chk("R13", "proto_err", int'(proto_err), int'(err_exp));
                    chk(tag, "perm after event", int'(qry_perm), perm_exp(ns));
                end
            end
        end

        // R12: network and processor in the same cycle on different lines
        evict_en = 1'b1;
        reach(B_S, 1);
        reach(B_S, 2);
        proc_valid = 1'b1; proc_op = 2'd2; proc_line = 2'd2;
        net_valid  = 1'b1; net_class = 4'd3; net_line = 2'd1;
        #1;
        chk("R12", "stall with network", int'(proc_stall), 1);
        @(negedge clk);
        proc_valid = 1'b0; net_valid = 1'b0;
        chk("R12", "msg_kind inv ack", int'(msg_kind), 4);
        chk("R12", "rsp_line", int'(rsp_line), 1);
        chk("R12", "evict_notice", int'(evict_notice), 1);
        qry_line = 2'd2; #0.5;
        chk("R12", "proc line untouched", int'(qry_perm), 2);
        qry_line = 2'd1; #0.5;
        chk("R12", "net line invalid", int'(qry_perm), 0);

        // R8: dirty flag travels with downgrade data, then line is shared
        reach(B_M, 3);
        step(0, 0, 1, 6, 3);
        chk("R8", "fetch fwd dirty", int'(msg_dirty), 1);
        chk("R8", "downgrade perm", int'(qry_perm), 2);
        step(1, 1, 0, 0, 3);
        chk("R3", "fetch hit after downgrade", int'(done_hit), 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule